// File: doc/BRIEF.md
# Vectored Interrupt Flag Controller

This block is the interrupt front end for a small 8-bit CPU core. Edge-type requests from general sources and from timer sources are caught in sticky flags. A flag is set only on a rising edge of its input and stays set until the CPU takes its vector or software clears it. Each flag is gated by its bit in one of two 8-bit mask registers. A separate level-sensitive external request has no flag and counts only while its pin is high. A single global enable qualifies every source.

The block selects the pending source with the lowest vector number, raises `cpu_irq` and presents that number on `cpu_vec`. The CPU handshake works like valid/ready. `cpu_irq` is the valid. `cpu_ack` is the ready, and a transfer happens in a cycle where both are high. The CPU may hold off `cpu_ack` for as long as it likes. While it does, the request stays up and `cpu_vec` follows whichever enabled source currently has the highest priority, so the number taken is the one shown in the acknowledging cycle. On a transfer the flag of the chosen source is cleared and the global enable drops. A `cpu_reti` pulse sets the global enable again. Saving the status register is left to software.

Top module: `vic_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `cpu_irq` is low.
- R2: A flag is set by a 0-to-1 change of its event input, sampled on the clock. An input held high does not set the flag again after software clears it. Only a new rising edge does.
- R3: Writing to a flag register clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged. If a rising edge and a clearing write hit the same flag in the same cycle, the flag stays set.
- R4: An event whose mask bit is 0 still sets its flag, and the flag is held. Once the mask bit is set, that source requests.
- R5: `cpu_irq` is high exactly when the global enable is 1 and at least one source is both pending and enabled. `cpu_vec` is the lowest such index. Index 0 is the level input. Indices 1 to 4 are general events 0 to 3. Indices 5 to 8 are timer events 0 to 3.
- R6: In a cycle with `cpu_irq` and `cpu_ack` both high, the flag of the source on `cpu_vec` is cleared and the global enable goes to 0 at that clock edge. From the next cycle on, `cpu_irq` is low.
- R7: A `cpu_reti` pulse sets the global enable, and a register write can set or clear it. An acknowledge in the same cycle wins over both. A register write wins over `cpu_reti`.
- R8: The level source has no flag. It requests in the same cycle that `ext_lvl` is high, provided general mask bit 0 and the global enable are both 1. When `ext_lvl` falls, the request is gone, and the level input never shows up in any flag register.
- R9: Flags that become pending while the global enable is 0 are kept. After the enable is restored, they are served one per acknowledge, lowest index first.
- R10: Register map on `reg_addr`. Address 0 is the general mask: bit 0 enables the level input, bits 1 to 4 enable general events 0 to 3. Address 1 is the timer mask, bits 0 to 3. Address 2 holds the general flags in bits 1 to 4 and reads 0 in bit 0. Address 3 holds the timer flags in bits 0 to 3. Address 4 holds the global enable in bit 0. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_ev | input | 4 | General event inputs |
| tmr_ev | input | 4 | Timer event inputs |
| ext_lvl | input | 1 | Level-sensitive external request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| cpu_irq | output | 1 | Interrupt request (valid) |
| cpu_vec | output | 4 | Vector number of the chosen source |
| cpu_ack | input | 1 | Vector taken (ready) |
| cpu_reti | input | 1 | Return from interrupt |

## Verification
An event edge shows in its flag, and in `cpu_irq`, one clock edge after the input rises. A mask write or global-enable change takes effect after the edge that writes it, while the level input and register reads act in the same cycle. An acknowledge clears the flag and drops `cpu_irq` at the next edge. The bench drives every input just after a rising edge and samples a few nanoseconds later or at the falling edge, so each result is read in the first cycle it is due. A scoreboard queue holds the vector expected for each acknowledge and compares it with `cpu_vec` in the acknowledging cycle.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_W = 8;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_GMASK = 3'd0;
  localparam logic [ADDR_W-1:0] A_TMASK = 3'd1;
  localparam logic [ADDR_W-1:0] A_GFLAG = 3'd2;
  localparam logic [ADDR_W-1:0] A_TFLAG = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd4;
endpackage

// File: rtl/vic_edge_flags.sv
module vic_edge_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] clr_w1c,
  input  logic [N-1:0] clr_ack,
  output logic [N-1:0] flags
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic rise;
    assign rise = ev[i] & ~prev_q[i];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        flags[i]  <= 1'b0;
      end else begin
        prev_q[i] <= ev[i];
        // a new edge dominates either clear
        flags[i]  <= rise | (flags[i] & ~clr_w1c[i] & ~clr_ack[i]);
      end
    end
  end
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int N = 9,
  parameter int W = 4
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/vic_irq_ctrl.sv
module vic_irq_ctrl
  import vic_pkg::*;
#(
  parameter int GEN_EV = 4,
  parameter int TMR_EV = 4,
  parameter int VEC_W  = $clog2(1 + GEN_EV + TMR_EV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GEN_EV-1:0] gen_ev,
  input  logic [TMR_EV-1:0] tmr_ev,
  input  logic              ext_lvl,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              cpu_irq,
  output logic [VEC_W-1:0]  cpu_vec,
  input  logic              cpu_ack,
  input  logic              cpu_reti
);
  localparam int NSRC  = 1 + GEN_EV + TMR_EV;
  localparam int T_OFS = 1 + GEN_EV;

  logic [REG_W-1:0]  gmask_q, tmask_q;
  logic              gie_q;
  logic [GEN_EV-1:0] gflags;
  logic [TMR_EV-1:0] tflags;
  logic [NSRC-1:0]   src_pend, src_en, src_live, ack_hot;
  logic              any_live, ack_fire;
  logic [GEN_EV-1:0] gclr;
  logic [TMR_EV-1:0] tclr;

  // register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gmask_q <= '0;
      tmask_q <= '0;
      gie_q   <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_GMASK) gmask_q <= reg_wdata;
      if (reg_wr && reg_addr == A_TMASK) tmask_q <= reg_wdata;
      if (ack_fire)                          gie_q <= 1'b0;
      else if (reg_wr && reg_addr == A_CTRL) gie_q <= reg_wdata[0];
      else if (cpu_reti)                     gie_q <= 1'b1;
    end
  end

  assign gclr = (reg_wr && reg_addr == A_GFLAG) ? reg_wdata[GEN_EV:1] : '0;
  assign tclr = (reg_wr && reg_addr == A_TFLAG) ? reg_wdata[TMR_EV-1:0] : '0;

  assign ack_fire = cpu_irq & cpu_ack;
  assign ack_hot  = ack_fire ? (NSRC'(1) << cpu_vec) : '0;

  vic_edge_flags #(.N(GEN_EV)) u_gen_flags (
    .clk(clk), .rst_n(rst_n), .ev(gen_ev), .clr_w1c(gclr),
    .clr_ack(ack_hot[GEN_EV:1]), .flags(gflags)
  );

  vic_edge_flags #(.N(TMR_EV)) u_tmr_flags (
    .clk(clk), .rst_n(rst_n), .ev(tmr_ev), .clr_w1c(tclr),
    .clr_ack(ack_hot[NSRC-1:T_OFS]), .flags(tflags)
  );

  assign src_pend = {tflags, gflags, ext_lvl};
  assign src_en   = {tmask_q[TMR_EV-1:0], gmask_q[GEN_EV:0]};
  assign src_live = src_pend & src_en;

  vic_prio_enc #(.N(NSRC), .W(VEC_W)) u_prio (
    .req(src_live), .any(any_live), .idx(cpu_vec)
  );

  assign cpu_irq = gie_q & any_live;

  // register reads
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_GMASK: reg_rdata = gmask_q;
      A_TMASK: reg_rdata = tmask_q;
      A_GFLAG: reg_rdata[GEN_EV:1] = gflags;
      A_TFLAG: reg_rdata[TMR_EV-1:0] = tflags;
      A_CTRL:  reg_rdata[0] = gie_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/vic_irq_ctrl_chk.sv
module vic_irq_ctrl_chk #(
  parameter int TMR_EV = 4,
  parameter int NSRC   = 9,
  parameter int VEC_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TMR_EV-1:0] tmr_ev,
  input logic              ext_lvl,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              cpu_irq,
  input logic [VEC_W-1:0]  cpu_vec,
  input logic              cpu_ack,
  input logic              cpu_reti,
  input logic              gie_q,
  input logic [7:0]        gmask_q,
  input logic [TMR_EV-1:0] tflags
);
  a_r6_ack_drops_request: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && cpu_ack) |=> (!gie_q && !cpu_irq));

  a_r7_reti_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_reti && !(cpu_irq && cpu_ack) && !(reg_wr && reg_addr == 3'd4)) |=> gie_q);

  a_r8_level_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_lvl && gmask_q[0] && gie_q) |-> (cpu_irq && cpu_vec == '0));

  a_r5_vector_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (cpu_vec < VEC_W'(NSRC)));

  a_r2_flag_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((tflags & ~$past(tflags) & ~$past(tmr_ev)) == '0));

  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd3 && tmr_ev == '0) |=> ((tflags & $past(reg_wdata[TMR_EV-1:0])) == '0));
endmodule

bind vic_irq_ctrl vic_irq_ctrl_chk #(.TMR_EV(TMR_EV), .NSRC(NSRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_ev(tmr_ev), .ext_lvl(ext_lvl), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cpu_irq(cpu_irq), .cpu_vec(cpu_vec),
  .cpu_ack(cpu_ack), .cpu_reti(cpu_reti), .gie_q(gie_q), .gmask_q(gmask_q), .tflags(tflags)
);

// File: tb/vic_irq_ctrl_test.sv
module vic_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] gen_ev = '0, tmr_ev = '0;
  logic       ext_lvl = 1'b0, reg_wr = 1'b0, cpu_ack = 1'b0, cpu_reti = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       cpu_irq;
  logic [3:0] cpu_vec;

  int n_cmp = 0, n_bad = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  vic_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .gen_ev(gen_ev), .tmr_ev(tmr_ev), .ext_lvl(ext_lvl),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq(cpu_irq), .cpu_vec(cpu_vec), .cpu_ack(cpu_ack), .cpu_reti(cpu_reti)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic slot();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    slot(); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    slot(); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    slot(); reg_addr = a; #2;
    chk(reg_rdata == e, tag, reg_rdata, e);
  endtask

  task automatic irq_is(input logic e, input string tag);
    #2 chk(cpu_irq == e, tag, cpu_irq, e);
  endtask

  task automatic serve(input int v);
    exp_q.push_back(v);
    slot(); cpu_ack = 1'b1;
    slot(); cpu_ack = 1'b0;
  endtask

  task automatic reti();
    slot(); cpu_reti = 1'b1;
    slot(); cpu_reti = 1'b0;
  endtask

  // scoreboard monitor: one pop per acknowledge
  always @(negedge clk) begin
    if (rst_n && cpu_irq && cpu_ack) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected acknowledge", cpu_vec, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(cpu_vec) == e, "R5/R9 vector at acknowledge", cpu_vec, e);
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) slot();
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 5; a++) rd(3'(a), 8'h00, "R1 register after reset");
    irq_is(1'b0, "R1 irq after reset");
    // R10 register map, R7 software enable
    wr(3'd0, 8'h1F); rd(3'd0, 8'h1F, "R10 general mask");
    wr(3'd1, 8'h00); rd(3'd1, 8'h00, "R10 timer mask");
    wr(3'd4, 8'h01); rd(3'd4, 8'h01, "R7 software sets enable");
    // R4 masked event is held
    slot(); tmr_ev[1] = 1'b1;
    slot(); tmr_ev[1] = 1'b0;
    rd(3'd3, 8'h02, "R4 flag held while masked");
    irq_is(1'b0, "R4 no request while masked");
    wr(3'd1, 8'h0F);
    irq_is(1'b1, "R4 request after enable");
    chk(cpu_vec == 4'd6, "R5 timer1 vector", cpu_vec, 6);
    serve(6);
    irq_is(1'b0, "R6 irq drops after acknowledge");
    rd(3'd3, 8'h00, "R6 flag cleared by acknowledge");
    rd(3'd4, 8'h00, "R6 enable cleared by acknowledge");
    // R2 held condition
    slot(); tmr_ev[0] = 1'b1;
    rd(3'd3, 8'h01, "R2 flag on rising edge");
    wr(3'd3, 8'h01);
    repeat (3) slot();
    rd(3'd3, 8'h00, "R2 held input does not re-set");
    slot(); tmr_ev[0] = 1'b0;
    slot(); tmr_ev[0] = 1'b1;
    rd(3'd3, 8'h01, "R2 new edge sets flag");
    tmr_ev[0] = 1'b0;
    wr(3'd3, 8'h01);
    // R3 write-1-to-clear
    slot(); tmr_ev[2] = 1'b1;
    slot(); tmr_ev[2] = 1'b0;
    wr(3'd3, 8'h00); rd(3'd3, 8'h04, "R3 zero write keeps flag");
    wr(3'd3, 8'h04); rd(3'd3, 8'h00, "R3 one write clears flag");
    slot(); gen_ev[2] = 1'b1; reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h08;
    slot(); reg_wr = 1'b0; gen_ev[2] = 1'b0;
    rd(3'd2, 8'h08, "R3 set wins over same-cycle clear");
    // R9 pending while disabled, served in order
    slot(); gen_ev[0] = 1'b1; tmr_ev[3] = 1'b1;
    slot(); gen_ev[0] = 1'b0; tmr_ev[3] = 1'b0;
    rd(3'd2, 8'h0A, "R9 general flags pending");
    rd(3'd3, 8'h08, "R9 timer flag pending");
    irq_is(1'b0, "R9 no request while disabled");
    reti(); serve(1);
    reti(); serve(3);
    reti(); serve(8);
    irq_is(1'b0, "R9 all served");
    rd(3'd2, 8'h00, "R9 general flags empty");
    // R8 level source
    reti();
    slot(); ext_lvl = 1'b1;
    irq_is(1'b1, "R8 level requests at once");
    chk(cpu_vec == 4'd0, "R8 level vector", cpu_vec, 0);
    serve(0);
    irq_is(1'b0, "R8 blocked after acknowledge");
    reti();
    irq_is(1'b1, "R8 level still active re-requests");
    slot(); ext_lvl = 1'b0;
    irq_is(1'b0, "R8 level forgotten when low");
    rd(3'd2, 8'h00, "R8 level has no flag");
    rd(3'd4, 8'h01, "R7 reti restored enable");
    // R7 acknowledge wins over reti
    slot(); ext_lvl = 1'b1;
    exp_q.push_back(0);
    slot(); cpu_ack = 1'b1; cpu_reti = 1'b1;
    slot(); cpu_ack = 1'b0; cpu_reti = 1'b0; ext_lvl = 1'b0;
    rd(3'd4, 8'h00, "R7 acknowledge beats reti");
    wr(3'd4, 8'h01); wr(3'd4, 8'h00);
    rd(3'd4, 8'h00, "R7 software clears enable");
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule